// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the combinational heart of one logic block in a programmable-logic fabric. It receives 36 routed input signals and forms 16 sum-of-products outputs, one per macrocell, plus six control-term outputs. Every product term can use any input in true or complemented form. Each output owns five private product terms that are always ORed into it. A shared pool of 32 product terms reaches the outputs through a fully programmable OR array, so one pool term can serve several outputs at once. Each control term is configured as either the AND or the OR of its selected literals.

The configuration is a single flat vector of 9014 bits. It arrives one bit per transfer over a valid/ready serial stream into a staging register. A commit strobe copies the staging register into the active configuration in one cycle. The stream's back-pressure rule is simple. `cfg_ready` is low during reset and in any cycle where `cfg_commit` is high, and high otherwise. A sender holds `cfg_bit` and `cfg_valid` steady until a cycle in which both `cfg_valid` and `cfg_ready` are high, and that bit is then taken at the rising edge. The outputs are pure combinational functions of the active configuration and `in_sig`. No register sits in the logic path.

Top module: `pla_logic_array`

## Requirements
- R1: After a synchronous reset, the active and staging configurations are all zero, `sop_out` and `ctl_out` are all zero, and `cfg_ready` is high once reset is released.
- R2: A bit is taken at a rising edge when `cfg_valid` and `cfg_ready` are both high. Each taken bit enters at the top of the staging vector and shifts it down one place, so after 9014 transfers the first bit sent sits at index 0. Layout from index 0: 118 product-term fields of 72 bits each. Terms are ordered private terms (output o, slot s at o*5+s), then pool terms 80..111, then control terms 112..117. Inside a field, bit 2k enables input k true and bit 2k+1 enables input k complemented. Next come the routing bits at 8496 + p*16 + o, which route pool term p to output o. Last are the control-term mode bits at 9008 + c.
- R3: When `cfg_commit` is high at a rising edge, the active configuration takes the staging contents, and the outputs follow the new configuration from that edge on. In a commit cycle `cfg_ready` is low and an offered bit is not taken.
- R4: Shifting bits into the staging register without a commit leaves `sop_out` and `ctl_out` unchanged.
- R5: A product term is the AND of its enabled literals. A term with no enabled literal is 0, and a term enabling both polarities of one input is 0.
- R6: Each output is the OR of its own five private terms together with its routed pool terms.
- R7: A pool term reaches output o only when its routing bit for o is set, and one pool term may drive several outputs at once.
- R8: A single output can combine all 37 terms, its five private terms and all 32 pool terms.
- R9: A control term with mode bit 0 is the AND of its enabled literals. With mode bit 1 it is the OR of them. With no enabled literal it is 0 in either mode.
- R10: The outputs follow `in_sig` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | A configuration bit is offered |
| cfg_ready | output | 1 | The offered bit is taken this cycle |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Copy staging into active configuration |
| in_sig | input | 36 | Routed input signals |
| sop_out | output | 16 | Sum-of-products outputs, one per macrocell |
| ctl_out | output | 6 | Control-term outputs |

## Verification
Four configurations are each shifted in and committed, and each is driven with several input patterns. The private-term setup uses zero, single-literal and conflicting-polarity patterns to separate true from complemented literals and to show that an empty or contradictory term stays at 0. The pool setup routes one term to three outputs and a second term to one of them, which shows whether routing is per output and whether terms are shared. A full 37-term OR is swept one input at a time, with each value checked one time unit after the inputs change. The control-term setup runs AND, OR and empty terms in both modes. It also offers a bit during a commit and then commits again, which exposes a staging register that accepts data while it is committing.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic {
    TERM_AND = 1'b0,
    TERM_OR  = 1'b1
  } term_kind_e;
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int CFG_W = 9014
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic             cfg_bit,
  input  logic             cfg_commit,
  output logic             cfg_ready,
  output logic [CFG_W-1:0] active_cfg
);
  logic [CFG_W-1:0] staging;
  logic             take;

  assign cfg_ready = !rst && !cfg_commit;
  assign take      = cfg_valid && cfg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      staging    <= '0;
      active_cfg <= '0;
    end else begin
      if (cfg_commit) active_cfg <= staging;
      if (take)       staging    <= {cfg_bit, staging[CFG_W-1:1]};
    end
  end

  // staging shifts down by one with the new bit on top
  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_ready) |=> (staging[CFG_W-1] == $past(cfg_bit)) &&
                                 (staging[CFG_W-2:0] == $past(staging[CFG_W-1:1])));

  assert_commit_load_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_commit |=> (active_cfg == $past(staging)));

  assert_no_take_on_commit_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_commit |=> $stable(staging));

  assert_active_held_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_commit |=> $stable(active_cfg));
endmodule

// File: rtl/pla_pterm.sv
module pla_pterm
  import pla_pkg::*;
#(
  parameter int N_IN = 36
) (
  input  logic [2*N_IN-1:0] lits,
  input  logic [N_IN-1:0]   in_sig,
  input  term_kind_e        kind,
  output logic              term_out
);
  logic any_lit;
  logic and_hit;
  logic or_hit;

  always_comb begin
    any_lit = 1'b0;
    and_hit = 1'b1;
    or_hit  = 1'b0;
    for (int k = 0; k < N_IN; k++) begin
      any_lit = any_lit | lits[2*k] | lits[2*k+1];
      if (lits[2*k]) begin
        and_hit = and_hit & in_sig[k];
        or_hit  = or_hit | in_sig[k];
      end
      if (lits[2*k+1]) begin
        and_hit = and_hit & ~in_sig[k];
        or_hit  = or_hit | ~in_sig[k];
      end
    end
    term_out = (kind == TERM_OR) ? or_hit : (any_lit & and_hit);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT  = 16,
  parameter int N_PRIV = 5,
  parameter int N_POOL = 32
) (
  input  logic [N_OUT*N_PRIV-1:0] priv_terms,
  input  logic [N_POOL-1:0]       pool_terms,
  input  logic [N_POOL*N_OUT-1:0] route,
  output logic [N_OUT-1:0]        sop_out
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_POOL-1:0] routed;
    for (genvar p = 0; p < N_POOL; p++) begin : g_pool
      assign routed[p] = pool_terms[p] & route[p*N_OUT + o];
    end
    assign sop_out[o] = (|priv_terms[o*N_PRIV +: N_PRIV]) | (|routed);
  end
endmodule

// File: rtl/pla_logic_array.sv
module pla_logic_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 36,
  parameter int N_OUT  = 16,
  parameter int N_PRIV = 5,
  parameter int N_POOL = 32,
  parameter int N_CT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_bit,
  input  logic              cfg_commit,
  input  logic [N_IN-1:0]   in_sig,
  output logic [N_OUT-1:0]  sop_out,
  output logic [N_CT-1:0]   ctl_out
);
  localparam int LIT_W      = 2 * N_IN;
  localparam int N_PRIV_T   = N_OUT * N_PRIV;
  localparam int POOL_BASE  = N_PRIV_T;
  localparam int CT_BASE    = POOL_BASE + N_POOL;
  localparam int N_TERMS    = CT_BASE + N_CT;
  localparam int ROUTE_BASE = N_TERMS * LIT_W;
  localparam int MODE_BASE  = ROUTE_BASE + N_POOL * N_OUT;
  localparam int CFG_W      = MODE_BASE + N_CT;

  logic [CFG_W-1:0]   cfg;
  logic [N_TERMS-1:0] term_val;

  pla_cfg_chain #(.CFG_W(CFG_W)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .cfg_valid  (cfg_valid),
    .cfg_bit    (cfg_bit),
    .cfg_commit (cfg_commit),
    .cfg_ready  (cfg_ready),
    .active_cfg (cfg)
  );

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    term_kind_e kind;
    if (t >= CT_BASE) begin : g_ct
      assign kind = term_kind_e'(cfg[MODE_BASE + t - CT_BASE]);
    end else begin : g_pt
      assign kind = TERM_AND;
    end
    pla_pterm #(.N_IN(N_IN)) u_term (
      .lits     (cfg[t*LIT_W +: LIT_W]),
      .in_sig   (in_sig),
      .kind     (kind),
      .term_out (term_val[t])
    );
  end

  pla_or_plane #(.N_OUT(N_OUT), .N_PRIV(N_PRIV), .N_POOL(N_POOL)) u_or (
    .priv_terms (term_val[N_PRIV_T-1:0]),
    .pool_terms (term_val[POOL_BASE +: N_POOL]),
    .route      (cfg[ROUTE_BASE +: N_POOL*N_OUT]),
    .sop_out    (sop_out)
  );

  assign ctl_out = term_val[CT_BASE +: N_CT];

  // no clocked element between inputs and outputs
  assert_comb_path_R10: assert property (@(posedge clk) disable iff (rst)
    ($stable(in_sig) && $stable(cfg)) |-> ($stable(sop_out) && $stable(ctl_out)));

  // an empty configuration yields all-zero outputs (empty terms are 0)
  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg == '0) |-> (sop_out == '0 && ctl_out == '0));
endmodule

// File: tb/pla_logic_array_test.sv
module pla_logic_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 36, N_OUT = 16, N_PRIV = 5, N_POOL = 32, N_CT = 6;
  localparam int LIT_W = 72;
  localparam int POOL_T = 80, CT_T = 112;
  localparam int ROUTE_B = 118 * 72;
  localparam int MODE_B = ROUTE_B + 512;
  localparam int CFG_W = MODE_B + 6;

  logic clk = 0, rst = 1, cfg_valid = 0, cfg_bit = 0, cfg_commit = 0;
  logic cfg_ready;
  logic [N_IN-1:0] in_sig = '0;
  logic [N_OUT-1:0] sop_out;
  logic [N_CT-1:0] ctl_out;
  logic [CFG_W-1:0] cv;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_logic_array uut (.clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .cfg_commit(cfg_commit), .in_sig(in_sig), .sop_out(sop_out),
    .ctl_out(ctl_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lit(input int term, input int k, input bit comp);
    cv[term*LIT_W + 2*k + (comp ? 1 : 0)] = 1'b1;
  endtask

  task automatic route(input int p, input int o);
    cv[ROUTE_B + p*N_OUT + o] = 1'b1;
  endtask

  task automatic send_cfg();
    for (int i = 0; i < CFG_W; i++) begin
      @(negedge clk); cfg_valid = 1'b1; cfg_bit = cv[i];
    end
    @(negedge clk); cfg_valid = 1'b0; cfg_bit = 1'b0;
  endtask

  task automatic commit(input bit offer);
    @(negedge clk); cfg_commit = 1'b1; cfg_valid = offer; cfg_bit = 1'b1;
    #1 chk("R3 ready low in commit", {31'b0, cfg_ready}, 32'd0);
    @(negedge clk); cfg_commit = 1'b0; cfg_valid = 1'b0; cfg_bit = 1'b0;
  endtask

  task automatic drive(input logic [N_IN-1:0] v);
    in_sig = v; #1;
  endtask

  task automatic t_reset();
    chk("R1 sop after reset", {16'b0, sop_out}, 32'd0);
    chk("R1 ctl after reset", {26'b0, ctl_out}, 32'd0);
    chk("R1 ready after reset", {31'b0, cfg_ready}, 32'd1);
  endtask

  function automatic logic [15:0] exp_priv(input logic [N_IN-1:0] v);
    logic [15:0] e = '0;
    e[3] = (v[0] & ~v[1]) | v[35];
    return e;
  endfunction

  task automatic t_private();
    logic [N_IN-1:0] pats [5];
    cv = '0;
    lit(3*5+0, 0, 0); lit(3*5+0, 1, 1);
    lit(3*5+4, 35, 0);
    lit(5*5+2, 7, 0); lit(5*5+2, 7, 1);
    lit(5*5+2, 0, 0); lit(5*5+2, 1, 0);
    drive('1);
    send_cfg();
    chk("R4 no change before commit", {16'b0, sop_out}, 32'd0);
    commit(0);
    pats[0] = '0; pats[1] = 36'h1; pats[2] = 36'h3;
    pats[3] = 36'h8_0000_0000; pats[4] = '1;
    foreach (pats[i]) begin
      drive(pats[i]);
      chk("R5 R6 private terms", {16'b0, sop_out}, {16'b0, exp_priv(pats[i])});
    end
  endtask

  function automatic logic [15:0] exp_pool(input logic [N_IN-1:0] v);
    logic [15:0] e = '0;
    logic p7 = v[10] & v[20];
    e[0] = p7; e[15] = p7; e[9] = p7 | ~v[5];
    return e;
  endfunction

  task automatic t_pool();
    logic [N_IN-1:0] pats [4];
    cv = '0;
    lit(POOL_T+7, 10, 0); lit(POOL_T+7, 20, 0);
    route(7, 0); route(7, 9); route(7, 15);
    lit(POOL_T+31, 5, 1); route(31, 9);
    send_cfg();
    commit(0);
    pats[0] = '0; pats[1] = 36'h20;
    pats[2] = (36'h1 << 10) | (36'h1 << 20) | 36'h20;
    pats[3] = (36'h1 << 10) | 36'h20;
    foreach (pats[i]) begin
      drive(pats[i]);
      chk("R7 pool routing", {16'b0, sop_out}, {16'b0, exp_pool(pats[i])});
    end
  endtask

  task automatic t_wide();
    cv = '0;
    for (int s = 0; s < 5; s++) lit(2*5+s, s, 0);
    for (int p = 0; p < 31; p++) begin lit(POOL_T+p, 5+p, 0); route(p, 2); end
    lit(POOL_T+31, 0, 0); lit(POOL_T+31, 1, 0); route(31, 2); route(31, 4);
    send_cfg();
    commit(0);
    drive('0);
    chk("R8 all zero", {16'b0, sop_out}, 32'd0);
    for (int k = 0; k < N_IN; k++) begin
      in_sig = 36'h1 << k; #1;
      chk("R8 R10 one hot input", {16'b0, sop_out}, 32'h4);
    end
    drive(36'h3);
    chk("R7 R8 shared term", {16'b0, sop_out}, 32'h14);
  endtask

  function automatic logic [5:0] exp_ct(input logic [N_IN-1:0] v);
    logic [5:0] e = '0;
    e[0] = v[3] & ~v[4];
    e[1] = v[3] | ~v[4];
    e[4] = v[35];
    return e;
  endfunction

  task automatic t_ctl();
    logic [N_IN-1:0] pats [6];
    cv = '0;
    lit(CT_T+0, 3, 0); lit(CT_T+0, 4, 1);
    lit(CT_T+1, 3, 0); lit(CT_T+1, 4, 1); cv[MODE_B+1] = 1'b1;
    cv[MODE_B+3] = 1'b1;
    lit(CT_T+4, 35, 0); cv[MODE_B+4] = 1'b1;
    lit(CT_T+5, 7, 0); lit(CT_T+5, 7, 1);
    send_cfg();
    commit(1);
    pats[0] = '0; pats[1] = 36'h8; pats[2] = 36'h10; pats[3] = 36'h18;
    pats[4] = 36'h8_0000_0000; pats[5] = '1;
    foreach (pats[i]) begin
      drive(pats[i]);
      chk("R9 control terms", {26'b0, ctl_out}, {26'b0, exp_ct(pats[i])});
      chk("R9 sop idle", {16'b0, sop_out}, 32'd0);
    end
    commit(0);
    drive(36'h8);
    chk("R3 bit offered in commit not taken", {26'b0, ctl_out}, {26'b0, exp_ct(36'h8)});
    drive(36'h10);
    chk("R2 R3 staging intact", {26'b0, ctl_out}, {26'b0, exp_ct(36'h10)});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_private();
    t_pool();
    t_wide();
    t_ctl();
    finish_run();
  end
endmodule